// File: doc/BRIEF.md
# Video Packet Stream Cleaner

This block sits on a ready/valid video stream between a source and a sink. The stream carries packets marked by start and end flags. The low nibble of each packet's first beat gives its type. Control packets declare the frame width, the frame height and an interlace code. Frame packets carry one pixel per beat. User packets carry anything else.

The block rewrites the stream so that every frame it emits is preceded by exactly one well-formed control packet, and the pixel count of that frame equals the declared width times height. It holds the last complete control packet and replays it just before the frame that uses it. It drops frames that have no usable control packet or whose size is out of range. It cuts frames that run long and fills frames that run short with gray pixels. It can also round the width down to a configured multiple, trimming every line to match.

While the block replays a control packet or inserts padding, it stalls the source. Everywhere else it passes beats straight through, with no storage beyond one control packet.

Top module: `vid_pkt_scrubber`

## Requirements
- R1: A packet whose first beat has a low nibble other than 0 or 15 is a user packet. It passes through unchanged, beat for beat, with its start and end flags intact.
- R2: A control packet is a header beat with low nibble 15, followed by nine data beats whose low nibbles carry, in order: width bits 15:12, 11:8, 7:4 and 3:0, then height bits 15:12 down to 3:0, then the interlace code. The emitted control packet uses the same layout with zero above the nibble and has its end flag on the tenth beat. It is followed by a frame header beat that is all zero.
- R3: When several complete control packets arrive before a frame, the frame uses the last one, and exactly one control packet is emitted, directly ahead of the frame header.
- R4: A control packet that ends before all nine data beats have arrived is discarded. Any earlier complete control packet stays in effect. Beats beyond the ninth are ignored.
- R5: A frame packet (low nibble 0) is dropped entirely when no complete control packet has arrived since the previous frame packet.
- R6: A frame is dropped when the rounded width is below MIN_W, the declared width is above MAX_W, or the height lies outside MIN_H to MAX_H.
- R7: With ILACE_EN set, a frame is dropped when bit 3 of the interlace code is set and the width exceeds IL_W or the height exceeds IL_H. Without bit 3, the same size passes.
- R8: The emitted width is the declared width rounded down to a multiple of MOD. Each input line, which is as long as the declared width, contributes only its first rounded-width beats.
- R9: Pixel beats beyond the declared size are removed, and the end flag goes out on the last allowed beat.
- R10: A frame that ends early is completed with gray beats of 8'h80 on every plane, and the end flag goes out on the last of them.
- R11: Under any pattern of sink backpressure and source gaps, the output matches R1 to R10. An output beat held by a low out_ready keeps its data and flags.
- R12: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | BPP*PLANES | Input beat |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | Input start of packet |
| in_eop | input | 1 | Input end of packet |
| in_ready | output | 1 | Block accepts the input beat |
| out_data | output | BPP*PLANES | Output beat |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | Output start of packet |
| out_eop | output | 1 | Output end of packet |
| out_ready | input | 1 | Sink accepts the output beat |

## Verification
Width alignment and padding can meet on the same input beat. This happens when a frame's end flag arrives on a column that the modulo trim discards, so that beat is swallowed and padding of the following rows starts in the next cycle. A directed case provokes it with a width of 10 under a modulo of 4 and a frame that ends at column 8 of its first line. Random frames of near-correct length land on the same coincidence by chance. A bench model compares the whole output, beat by beat, including the position of the end flag.

// File: rtl/vid_pkt_scrubber.sv
`timescale 1ns/1ps
module vid_pkt_scrubber #(
  parameter int BPP      = 8,
  parameter int PLANES   = 3,
  parameter int MAX_W    = 4096,
  parameter int MAX_H    = 2160,
  parameter int MIN_W    = 16,
  parameter int MIN_H    = 16,
  parameter int MOD      = 1,
  parameter bit ILACE_EN = 1'b0,
  parameter int IL_W     = 1920,
  parameter int IL_H     = 540
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BPP*PLANES-1:0]   in_data,
  input  logic                    in_valid,
  input  logic                    in_sop,
  input  logic                    in_eop,
  output logic                    in_ready,
  output logic [BPP*PLANES-1:0]   out_data,
  output logic                    out_valid,
  output logic                    out_sop,
  output logic                    out_eop,
  input  logic                    out_ready
);
  localparam int DW = BPP * PLANES;
  localparam logic [15:0] LMAXW = 16'(MAX_W);
  localparam logic [15:0] LMAXH = 16'(MAX_H);
  localparam logic [15:0] LMINW = 16'(MIN_W);
  localparam logic [15:0] LMINH = 16'(MIN_H);
  localparam logic [15:0] LILW  = 16'(IL_W);
  localparam logic [15:0] LILH  = 16'(IL_H);
  localparam logic [15:0] MODV  = (MOD > 1) ? 16'(MOD) : 16'd1;
  localparam logic [DW-1:0] GRAY = {PLANES{1'b1, {(BPP-1){1'b0}}}};

  typedef enum logic [2:0] {S_HDR, S_CTL, S_EMIT, S_FRM, S_PAD, S_DROP, S_USER} st_t;
  st_t st;

  logic [3:0]  cnt, ecnt, si, ci, enib;
  logic [15:0] sw, sh, cw, ch, col;
  logic [31:0] ocnt;
  logic        have, hdr_eop;

  wire [3:0]  nib      = in_data[3:0];
  wire [15:0] wr       = cw - (cw % MODV);
  wire [31:0] otot     = 32'(wr) * 32'(ch);
  wire        il_big   = ILACE_EN && ci[3] && (cw > LILW || ch > LILH);
  wire        dims_ok  = have && wr >= LMINW && cw <= LMAXW &&
                         ch >= LMINH && ch <= LMAXH && !il_big;
  wire        keep     = col < wr;
  wire        last_o   = ocnt == otot - 32'd1;
  wire        hdr_user = in_sop && nib != 4'h0 && nib != 4'hF;
  wire        in_fire  = in_valid && in_ready;
  wire        out_fire = out_valid && out_ready;

  wire [15:0] sw_n = (cnt < 4'd4) ? {sw[11:0], nib} : sw;
  wire [15:0] sh_n = (cnt >= 4'd4 && cnt < 4'd8) ? {sh[11:0], nib} : sh;
  wire [3:0]  si_n = (cnt == 4'd8) ? nib : si;

  always_comb begin
    case (ecnt)
      4'd0:    enib = 4'hF;
      4'd1:    enib = wr[15:12];
      4'd2:    enib = wr[11:8];
      4'd3:    enib = wr[7:4];
      4'd4:    enib = wr[3:0];
      4'd5:    enib = ch[15:12];
      4'd6:    enib = ch[11:8];
      4'd7:    enib = ch[7:4];
      4'd8:    enib = ch[3:0];
      4'd9:    enib = ci;
      default: enib = 4'h0;
    endcase
  end

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    out_sop   = 1'b0;
    out_eop   = 1'b0;
    in_ready  = 1'b0;
    case (st)
      S_HDR: begin
        if (in_valid && hdr_user) begin
          out_valid = 1'b1;
          out_data  = in_data;
          out_sop   = 1'b1;
          out_eop   = in_eop;
          in_ready  = out_ready;
        end else begin
          in_ready  = 1'b1;
        end
      end
      S_CTL, S_DROP: in_ready = 1'b1;
      S_USER: begin
        out_valid = in_valid;
        out_data  = in_data;
        out_eop   = in_eop;
        in_ready  = out_ready;
      end
      S_EMIT: begin
        out_valid = 1'b1;
        out_data  = {{(DW-4){1'b0}}, enib};
        out_sop   = (ecnt == 4'd0) || (ecnt == 4'd10);
        out_eop   = (ecnt == 4'd9);
      end
      S_FRM: begin
        if (keep) begin
          out_valid = in_valid;
          out_data  = in_data;
          out_eop   = last_o;
          in_ready  = out_ready;
        end else begin
          in_ready  = 1'b1;
        end
      end
      S_PAD: begin
        out_valid = 1'b1;
        out_data  = GRAY;
        out_eop   = last_o;
      end
      default: in_ready = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_HDR;
      cnt     <= '0;
      ecnt    <= '0;
      sw      <= '0;
      sh      <= '0;
      si      <= '0;
      cw      <= '0;
      ch      <= '0;
      ci      <= '0;
      col     <= '0;
      ocnt    <= '0;
      have    <= 1'b0;
      hdr_eop <= 1'b0;
    end else begin
      case (st)
        S_HDR: begin
          if (in_fire && in_sop) begin
            if (nib == 4'hF) begin
              cnt <= '0;
              if (!in_eop) st <= S_CTL;
            end else if (nib == 4'h0) begin
              have <= 1'b0;
              if (dims_ok) begin
                hdr_eop <= in_eop;
                ecnt    <= '0;
                st      <= S_EMIT;
              end else if (!in_eop) begin
                st <= S_DROP;
              end
            end else if (!in_eop) begin
              st <= S_USER;
            end
          end
        end
        S_CTL: begin
          if (in_fire) begin
            sw <= sw_n;
            sh <= sh_n;
            si <= si_n;
            if (cnt != 4'd9) cnt <= cnt + 4'd1;
            if (in_eop) begin
              st <= S_HDR;
              if (cnt >= 4'd8) begin
                cw   <= sw_n;
                ch   <= sh_n;
                ci   <= si_n;
                have <= 1'b1;
              end
            end
          end
        end
        S_EMIT: begin
          if (out_fire) begin
            if (ecnt == 4'd10) begin
              col  <= '0;
              ocnt <= '0;
              st   <= hdr_eop ? S_PAD : S_FRM;
            end else begin
              ecnt <= ecnt + 4'd1;
            end
          end
        end
        S_FRM: begin
          if (in_fire) begin
            col <= (col == cw - 16'd1) ? '0 : col + 16'd1;
            if (keep) begin
              ocnt <= ocnt + 32'd1;
              if (last_o)      st <= in_eop ? S_HDR : S_DROP;
              else if (in_eop) st <= S_PAD;
            end else if (in_eop) begin
              st <= S_PAD;
            end
          end
        end
        S_PAD: begin
          if (out_fire) begin
            ocnt <= ocnt + 32'd1;
            if (last_o) st <= S_HDR;
          end
        end
        S_DROP: if (in_fire && in_eop) st <= S_HDR;
        S_USER: if (in_fire && in_eop) st <= S_HDR;
        default: st <= S_HDR;
      endcase
    end
  end
endmodule

// File: rtl/vid_pkt_scrubber_chk.sv
`timescale 1ns/1ps
module vid_pkt_scrubber_chk #(
  parameter int DW  = 24,
  parameter int MOD = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_sop,
  input logic          out_eop,
  input logic [DW-1:0] out_data
);
  localparam logic [15:0] MODV = (MOD > 1) ? 16'(MOD) : 16'd1;

  wire fire = out_valid && out_ready;
  logic        in_pkt, in_ctl, in_frm, ctl_done;
  logic [3:0]  idx;
  logic [15:0] ow, oh;
  logic [31:0] fcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt   <= 1'b0;
      in_ctl   <= 1'b0;
      in_frm   <= 1'b0;
      ctl_done <= 1'b0;
      idx      <= '0;
      ow       <= '0;
      oh       <= '0;
      fcnt     <= '0;
    end else if (fire) begin
      in_pkt <= !out_eop;
      if (out_sop) begin
        in_ctl   <= out_data[3:0] == 4'hF;
        in_frm   <= out_data[3:0] == 4'h0;
        ctl_done <= 1'b0;
        idx      <= 4'd1;
        fcnt     <= '0;
      end else begin
        if (idx != 4'hF) idx <= idx + 4'd1;
        if (in_ctl && idx >= 4'd1 && idx <= 4'd4) ow <= {ow[11:0], out_data[3:0]};
        if (in_ctl && idx >= 4'd5 && idx <= 4'd8) oh <= {oh[11:0], out_data[3:0]};
        if (in_ctl && out_eop) ctl_done <= 1'b1;
        if (in_frm) fcnt <= fcnt + 32'd1;
      end
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

  assert_framing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !out_sop |-> in_pkt);

  assert_ctl_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && out_sop && out_data[3:0] == 4'h0 |-> ctl_done);

  assert_ctl_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_ctl && !out_sop |-> (out_eop == (idx == 4'd9)));

  // R10 as well: padded frames end exactly at the declared size
  assert_frame_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_frm && !out_sop |-> (out_eop == (fcnt + 32'd1 == 32'(ow) * 32'(oh))));

  assert_width_mod_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_ctl && !out_sop && out_eop |-> (ow % MODV == 16'd0));
endmodule

bind vid_pkt_scrubber vid_pkt_scrubber_chk #(.DW(DW), .MOD(MOD)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_sop(out_sop),
  .out_eop(out_eop),
  .out_data(out_data)
);

// File: tb/sim_vid_pkt_scrubber.sv
`timescale 1ns/1ps
module sim_vid_pkt_scrubber;
  localparam int BPP = 8, PLANES = 3, DW = 24;
  localparam int MAX_W = 16, MAX_H = 8, MIN_W = 4, MIN_H = 2, MOD = 4, IL_W = 12, IL_H = 4;
  localparam logic [DW-1:0] GRAY = 24'h808080;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] in_data = '0, out_data;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_ready;
  logic out_valid, out_sop, out_eop, out_ready = 1'b0;

  always #4 clk = ~clk;

  vid_pkt_scrubber #(.BPP(BPP), .PLANES(PLANES), .MAX_W(MAX_W), .MAX_H(MAX_H),
    .MIN_W(MIN_W), .MIN_H(MIN_H), .MOD(MOD), .ILACE_EN(1'b1), .IL_W(IL_W), .IL_H(IL_H)) u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_ready(out_ready));

  int checks = 0, fails = 0;
  bit gap_en = 1'b1, done = 1'b0;
  logic [DW-1:0] pkt[$];
  logic [DW+1:0] expq[$], gotq[$];
  int m_have = 0, m_w = 0, m_h = 0, m_i = 0;

  always @(negedge clk) out_ready = ($urandom % 4) != 0;

  always @(negedge clk) begin
    #3;
    if (rst_n && out_valid && out_ready) gotq.push_back({out_sop, out_eop, out_data});
  end

  function automatic logic [DW-5:0] rhi();
    logic [31:0] r = $urandom;
    return r[DW-5:0];
  endfunction

  task automatic mk_ctl(int w, int h, int il, int nb);
    pkt.delete();
    pkt.push_back({rhi(), 4'hF});
    for (int k = 0; k < nb; k++) begin
      int v;
      if (k < 4)       v = w >> (4 * (3 - k));
      else if (k < 8)  v = h >> (4 * (7 - k));
      else if (k == 8) v = il;
      else             v = int'($urandom);
      pkt.push_back({rhi(), 4'(v)});
    end
  endtask

  task automatic mk_frame(int n);
    pkt.delete();
    pkt.push_back({rhi(), 4'h0});
    for (int k = 0; k < n; k++) pkt.push_back(DW'($urandom));
  endtask

  task automatic mk_user(int t, int n);
    pkt.delete();
    pkt.push_back({rhi(), 4'(t)});
    for (int k = 1; k < n; k++) pkt.push_back(DW'($urandom));
  endtask

  task automatic model_pkt();
    int n = pkt.size();
    logic [3:0] t = pkt[0][3:0];
    if (t == 4'hF) begin
      if (n >= 10) begin
        m_w = int'({pkt[1][3:0], pkt[2][3:0], pkt[3][3:0], pkt[4][3:0]});
        m_h = int'({pkt[5][3:0], pkt[6][3:0], pkt[7][3:0], pkt[8][3:0]});
        m_i = int'(pkt[9][3:0]);
        m_have = 1;
      end
    end else if (t == 4'h0) begin
      int wr = m_w - (m_w % MOD);
      bit ok = (m_have != 0) && wr >= MIN_W && m_w <= MAX_W && m_h >= MIN_H && m_h <= MAX_H &&
               !(((m_i & 8) != 0) && (m_w > IL_W || m_h > IL_H));
      m_have = 0;
      if (ok) begin
        logic [15:0] w16 = 16'(wr), h16 = 16'(m_h);
        logic [3:0] nb[9];
        nb = '{w16[15:12], w16[11:8], w16[7:4], w16[3:0], h16[15:12], h16[11:8], h16[7:4], h16[3:0], 4'(m_i)};
        expq.push_back({2'b10, 20'h0, 4'hF});
        for (int k = 0; k < 9; k++) expq.push_back({1'b0, k == 8, 20'h0, nb[k]});
        expq.push_back({2'b10, 24'h0});
        for (int k = 0; k < wr * m_h; k++) begin
          int idx = (k / wr) * m_w + (k % wr) + 1;
          expq.push_back({1'b0, k == wr * m_h - 1, (idx < n) ? pkt[idx] : GRAY});
        end
      end
    end else begin
      for (int k = 0; k < n; k++) expq.push_back({k == 0, k == n - 1, pkt[k]});
    end
  endtask

  task automatic put(input logic [DW-1:0] d, input logic s, input logic e);
    bit acc = 1'b0;
    @(negedge clk);
    while (gap_en && ($urandom % 4) == 0) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
    while (!acc) begin
      #3;
      acc = in_ready;
      @(posedge clk);
      if (!acc) @(negedge clk);
    end
  endtask

  task automatic go();
    model_pkt();
    for (int i = 0; i < pkt.size(); i++) put(pkt[i], i == 0, i == pkt.size() - 1);
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic check_q(string tag);
    int t = 0;
    bit bad = 1'b0;
    while (gotq.size() < expq.size() && t < 5000) begin
      @(posedge clk);
      t++;
    end
    repeat (40) @(posedge clk);
    checks++;
    if (gotq.size() != expq.size()) begin
      bad = 1'b1;
      $display("FAIL %s: beat count got %0d expected %0d", tag, gotq.size(), expq.size());
    end else begin
      for (int k = 0; k < expq.size() && !bad; k++)
        if (gotq[k] !== expq[k]) begin
          bad = 1'b1;
          $display("FAIL %s: beat %0d got %h expected %h", tag, k, gotq[k], expq[k]);
        end
    end
    if (bad) fails++;
    gotq.delete();
    expq.delete();
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog: got no completion, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #3;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R12: got valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
    end

    mk_user(5, 4); go(); mk_user(3, 1); go();
    check_q("R1 user pass-through");

    mk_ctl(8, 3, 0, 10); go(); mk_frame(24); go();
    check_q("R2 exact frame");

    mk_ctl(12, 2, 0, 10); go(); mk_ctl(8, 2, 0, 10); go(); mk_user(7, 3); go(); mk_frame(16); go();
    check_q("R3 last control wins");

    mk_ctl(8, 2, 0, 10); go(); mk_ctl(16, 4, 0, 6); go(); mk_frame(16); go();
    mk_ctl(8, 2, 0, 5); go(); mk_frame(16); go();
    check_q("R4 broken control");

    mk_frame(16); go(); mk_ctl(8, 2, 0, 11); go(); mk_frame(16); go(); mk_frame(16); go();
    check_q("R5 frame without control");

    mk_ctl(20, 2, 0, 10); go(); mk_frame(40); go();
    mk_ctl(8, 1, 0, 10); go(); mk_frame(8); go();
    mk_ctl(8, 9, 0, 10); go(); mk_frame(72); go();
    mk_ctl(3, 2, 0, 10); go(); mk_frame(6); go();
    mk_ctl(16, 8, 0, 10); go(); mk_frame(128); go();
    mk_ctl(4, 2, 0, 10); go(); mk_frame(8); go();
    check_q("R6 size limits");

    mk_ctl(16, 4, 8, 10); go(); mk_frame(64); go();
    mk_ctl(12, 4, 8, 10); go(); mk_frame(48); go();
    mk_ctl(16, 4, 0, 10); go(); mk_frame(64); go();
    check_q("R7 interlaced size");

    mk_ctl(10, 3, 0, 10); go(); mk_frame(30); go();
    check_q("R8 modulo trim");

    mk_ctl(8, 2, 0, 10); go(); mk_frame(23); go();
    check_q("R9 long frame clipped");

    mk_ctl(8, 2, 0, 10); go(); mk_frame(5); go();
    mk_ctl(4, 3, 0, 10); go(); mk_frame(0); go();
    check_q("R10 short frame padded");

    mk_ctl(10, 2, 0, 10); go(); mk_frame(9); go();
    mk_ctl(10, 2, 0, 10); go(); mk_frame(19); go();
    check_q("R8 R10 trim meets pad");

    for (int b = 0; b < 6; b++) begin
      gap_en = (b % 2) == 0;
      for (int p = 0; p < 10; p++) begin
        int r = int'($urandom % 5);
        if (r == 0) mk_ctl(int'($urandom % 21), int'($urandom % 11), int'($urandom % 16), 10 + int'($urandom % 3));
        else if (r == 1) mk_ctl(int'($urandom % 21), int'($urandom % 11), 0, int'($urandom % 9));
        else if (r == 4) mk_user(1 + int'($urandom % 14), 1 + int'($urandom % 4));
        else begin
          int n = m_w * m_h + int'($urandom % 11) - 5;
          if (n < 0) n = 0;
          if (n > 220) n = 220;
          mk_frame(n);
        end
        go();
      end
      check_q("R11 random stream");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule